// File: doc/BRIEF.md
# Processor Debug Halt Controller

This block gives an external debug host run control over a simple in-order processor core. It watches the addresses of instructions that retire and of the data accesses they make, compares them against a parameterised set of instruction-address breakpoints and data-address watchpoints, and freezes the core pipeline through a registered run enable when one of them matches. The host can also stop, resume, single-step and reset the core through a small command port, and a level on the external stop input halts the core after a short drain of further retired instructions.

All halt causes share one sticky halted flag. It stays set until the host resumes the core, and because it is a clean registered level it can be wired to the external stop input of other controllers. A halt in one core then stops every core in the group. When the controller halts, it latches a cause code and the address of the halting instruction. A register access port lets the host read and write a stand-in for the core's general-purpose registers, program the comparators, and read the halt cause, halt address, status and version. The status and version registers cannot be written.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: After the synchronous reset, `halted` is 0, `core_run` is 1 and `core_rst` is 0. The cause register (address 8) reads 0, the status register (address 11: bit 0 halted, bit 1 stepping) reads 0 and the version register (address 10) reads 16'h0A51.
- R2: An instruction retires in any cycle where `core_run` and `inst_valid` are both 1. If the retiring instruction's address equals the address of an enabled breakpoint, then from the next cycle `halted` is 1 and `core_run` is 0. The cause reads 1 and the halt address (address 9) reads that instruction address. Breakpoint i has its address at register 16+2i and its enable in bit 0 of register 17+2i. A disabled breakpoint never matches.
- R3: Watchpoint j has its address at register 24+2j. Register 25+2j holds the enable (bit 0), a read qualifier (bit 1) and a write qualifier (bit 2). A retiring instruction whose data access (`dmem_valid`) hits an enabled watchpoint halts the core with cause 2 only if the access direction (`dmem_wr` = 1 for a write) is qualified. The halt address is the instruction address.
- R4: Host command stop (`cmd_op` = 1) while the core runs halts it from the next cycle with cause 0. The halt address is the instruction retiring in that cycle, otherwise the last instruction that retired.
- R5: `ext_stop` passes a two-stage synchronizer. A drain begins on the first clock edge at which the synchronized level is seen while the core runs. The core halts after DRAIN (3) further retirements, with cause 3 and the address of the last of them.
- R6: `halted` stays 1 until a resume command (`cmd_op` = 2) or a reset command is accepted. On the next cycle after a resume, `halted` is 0 and `core_run` is 1.
- R7: A step command (`cmd_op` = 3) while halted sets `core_run` to 1 and leaves `halted` at 1. After exactly one retirement, `core_run` returns to 0 and the cause reads 4 with that instruction's address.
- R8: A reset command (`cmd_op` = 4) drives `core_rst` to 1 for exactly one cycle, starting the next cycle. It clears `halted`, the cause and the halt address to 0 and leaves the breakpoint registers unchanged.
- R9: The general-purpose registers at addresses 0 to 7 are written when `reg_req` and `reg_we` are 1. A read (`reg_req` with `reg_we` = 0) presents the value on `reg_rdata` from the next cycle.
- R10: Writes to the cause, halt address, version and status registers (addresses 8 to 11) are ignored.
- R11: When halt causes occur in the same cycle, breakpoint beats watchpoint, watchpoint beats the end of an external drain, and that beats host stop.
- R12: The codes 0, 5, 6 and 7, and a step command while the core runs, leave `halted` and `core_run` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inst_valid | input | 1 | Core presents an instruction ready to retire |
| inst_addr | input | AW | Address of that instruction |
| dmem_valid | input | 1 | The instruction makes a data access |
| dmem_wr | input | 1 | Data access is a write (0 = read) |
| dmem_addr | input | AW | Data access address |
| ext_stop | input | 1 | Asynchronous external stop request |
| cmd_valid | input | 1 | Host command strobe |
| cmd_op | input | 3 | Command code: 1 stop, 2 resume, 3 step, 4 reset |
| reg_req | input | 1 | Register access strobe |
| reg_we | input | 1 | Register access is a write |
| reg_addr | input | RAW | Register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data, one cycle after the request |
| halted | output | 1 | Sticky halted status |
| core_run | output | 1 | Pipeline advance enable to the core |
| core_rst | output | 1 | One-cycle core reset pulse |

## Verification
If the run-state register is wrong, `halted` or `core_run` disagrees with the bench model on the very next cycle after the event that should have changed it. A wrong drain count shows up as a halt one or more retirements early or late. That changes the latched halt address, which the next host read exposes one cycle after its request. Corrupt comparator or cause storage stays hidden until an instruction or access reaches the programmed address, or until the host reads the register back.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;
  typedef enum logic [2:0] {
    CAUSE_HOST = 3'd0,
    CAUSE_BRK  = 3'd1,
    CAUSE_WCH  = 3'd2,
    CAUSE_EXT  = 3'd3,
    CAUSE_STEP = 3'd4
  } cause_e;

  typedef enum logic [1:0] {M_RUN, M_HALT, M_STEP} mode_e;

  localparam logic [2:0] OP_STOP   = 3'd1;
  localparam logic [2:0] OP_RESUME = 3'd2;
  localparam logic [2:0] OP_STEP   = 3'd3;
  localparam logic [2:0] OP_RESET  = 3'd4;

  localparam int RA_CAUSE    = 8;
  localparam int RA_HADDR    = 9;
  localparam int RA_VER      = 10;
  localparam int RA_STAT     = 11;
  localparam int RA_BRK_BASE = 16;
  localparam int RA_WCH_BASE = 24;
endpackage

// File: rtl/dbg_sync.sv
module dbg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/dbg_cmp_bank.sv
module dbg_cmp_bank #(
  parameter int N  = 2,
  parameter int AW = 16
) (
  input  logic            valid,
  input  logic            is_wr,
  input  logic [AW-1:0]   addr,
  input  logic [N*AW-1:0] ent_addr,
  input  logic [N-1:0]    ent_en,
  input  logic [N-1:0]    ent_rd,
  input  logic [N-1:0]    ent_wr,
  output logic            hit
);
  logic [N-1:0] m;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign m[i] = valid && ent_en[i] && (ent_addr[i*AW +: AW] == addr) &&
                  (is_wr ? ent_wr[i] : ent_rd[i]);
  end

  assign hit = |m;
endmodule

// File: rtl/dbg_regport.sv
module dbg_regport #(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int RAW   = 5,
  parameter int N_GPR = 8,
  parameter int N_BRK = 2,
  parameter int N_WCH = 2,
  parameter logic [DW-1:0] VERSION = 16'h0A51
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              we,
  input  logic [RAW-1:0]    addr,
  input  logic [DW-1:0]     wdata,
  input  logic [2:0]        cause,
  input  logic [AW-1:0]     haddr,
  input  logic              halted,
  input  logic              stepping,
  output logic [DW-1:0]     rdata,
  output logic [N_BRK*AW-1:0] brk_addr,
  output logic [N_BRK-1:0]  brk_en,
  output logic [N_WCH*AW-1:0] wch_addr,
  output logic [N_WCH-1:0]  wch_en,
  output logic [N_WCH-1:0]  wch_rd,
  output logic [N_WCH-1:0]  wch_wr
);
  import dbg_halt_pkg::*;

  localparam int GIDX = (N_GPR > 1) ? $clog2(N_GPR) : 1;

  function automatic logic [RAW-1:0] slot(input int base, input int i, input int k);
    return RAW'(base + 2 * i + k);
  endfunction

  logic [DW-1:0] gpr [N_GPR];
  logic [AW-1:0] brk_a [N_BRK];
  logic [AW-1:0] wch_a [N_WCH];
  logic [DW-1:0] rd_mux;
  logic          gpr_sel;

  assign gpr_sel = addr < RAW'(N_GPR);

  // register file kept free of reset so it maps to distributed RAM
  always_ff @(posedge clk) begin
    if (req && we && gpr_sel) gpr[addr[GIDX-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_BRK; i++) begin
        brk_a[i]  <= '0;
        brk_en[i] <= 1'b0;
      end
      for (int j = 0; j < N_WCH; j++) begin
        wch_a[j]  <= '0;
        wch_en[j] <= 1'b0;
        wch_rd[j] <= 1'b0;
        wch_wr[j] <= 1'b0;
      end
    end else if (req && we) begin
      for (int i = 0; i < N_BRK; i++) begin
        if (addr == slot(RA_BRK_BASE, i, 0)) brk_a[i]  <= wdata[AW-1:0];
        if (addr == slot(RA_BRK_BASE, i, 1)) brk_en[i] <= wdata[0];
      end
      for (int j = 0; j < N_WCH; j++) begin
        if (addr == slot(RA_WCH_BASE, j, 0)) wch_a[j] <= wdata[AW-1:0];
        if (addr == slot(RA_WCH_BASE, j, 1)) begin
          wch_en[j] <= wdata[0];
          wch_rd[j] <= wdata[1];
          wch_wr[j] <= wdata[2];
        end
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (gpr_sel)                   rd_mux = gpr[addr[GIDX-1:0]];
    if (addr == RAW'(RA_CAUSE))    rd_mux = DW'(cause);
    if (addr == RAW'(RA_HADDR))    rd_mux = DW'(haddr);
    if (addr == RAW'(RA_VER))      rd_mux = VERSION;
    if (addr == RAW'(RA_STAT))     rd_mux = DW'({stepping, halted});
    for (int i = 0; i < N_BRK; i++) begin
      if (addr == slot(RA_BRK_BASE, i, 0)) rd_mux = DW'(brk_a[i]);
      if (addr == slot(RA_BRK_BASE, i, 1)) rd_mux = DW'(brk_en[i]);
    end
    for (int j = 0; j < N_WCH; j++) begin
      if (addr == slot(RA_WCH_BASE, j, 0)) rd_mux = DW'(wch_a[j]);
      if (addr == slot(RA_WCH_BASE, j, 1)) rd_mux = DW'({wch_wr[j], wch_rd[j], wch_en[j]});
    end
  end

  always_ff @(posedge clk) begin
    if (rst)      rdata <= '0;
    else if (req) rdata <= rd_mux;
  end

  for (genvar i = 0; i < N_BRK; i++) begin : g_brk_flat
    assign brk_addr[i*AW +: AW] = brk_a[i];
  end
  for (genvar j = 0; j < N_WCH; j++) begin : g_wch_flat
    assign wch_addr[j*AW +: AW] = wch_a[j];
  end
endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
  import dbg_halt_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int RAW   = 5,
  parameter int N_GPR = 8,
  parameter int N_BRK = 2,
  parameter int N_WCH = 2,
  parameter int DRAIN = 3,
  parameter logic [DW-1:0] VERSION = 16'h0A51
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           inst_valid,
  input  logic [AW-1:0]  inst_addr,
  input  logic           dmem_valid,
  input  logic           dmem_wr,
  input  logic [AW-1:0]  dmem_addr,
  input  logic           ext_stop,
  input  logic           cmd_valid,
  input  logic [2:0]     cmd_op,
  input  logic           reg_req,
  input  logic           reg_we,
  input  logic [RAW-1:0] reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  output logic           halted,
  output logic           core_run,
  output logic           core_rst
);
  localparam int CW = $clog2(DRAIN + 1);

  mode_e          mode, mode_n;
  cause_e         cause, cause_n;
  logic [AW-1:0]  haddr, haddr_n, last_pc;
  logic           drain_on, drain_n;
  logic [CW-1:0]  cnt, cnt_n;
  logic           retire, brk_hit, wch_hit, ext_s, halt_now;
  logic           op_stop, op_resume, op_step, op_reset;

  logic [N_BRK*AW-1:0] brk_addr;
  logic [N_BRK-1:0]    brk_en;
  logic [N_WCH*AW-1:0] wch_addr;
  logic [N_WCH-1:0]    wch_en, wch_rd, wch_wr;

  assign retire    = core_run && inst_valid;
  assign op_stop   = cmd_valid && (cmd_op == OP_STOP);
  assign op_resume = cmd_valid && (cmd_op == OP_RESUME);
  assign op_step   = cmd_valid && (cmd_op == OP_STEP);
  assign op_reset  = cmd_valid && (cmd_op == OP_RESET);

  dbg_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .d(ext_stop), .q(ext_s)
  );

  dbg_cmp_bank #(.N(N_BRK), .AW(AW)) u_brk (
    .valid(retire), .is_wr(1'b0), .addr(inst_addr),
    .ent_addr(brk_addr), .ent_en(brk_en), .ent_rd(brk_en), .ent_wr(brk_en),
    .hit(brk_hit)
  );

  dbg_cmp_bank #(.N(N_WCH), .AW(AW)) u_wch (
    .valid(retire && dmem_valid), .is_wr(dmem_wr), .addr(dmem_addr),
    .ent_addr(wch_addr), .ent_en(wch_en), .ent_rd(wch_rd), .ent_wr(wch_wr),
    .hit(wch_hit)
  );

  dbg_regport #(
    .AW(AW), .DW(DW), .RAW(RAW), .N_GPR(N_GPR),
    .N_BRK(N_BRK), .N_WCH(N_WCH), .VERSION(VERSION)
  ) u_regs (
    .clk(clk), .rst(rst), .req(reg_req), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .cause(cause), .haddr(haddr), .halted(halted),
    .stepping(mode == M_STEP), .rdata(reg_rdata),
    .brk_addr(brk_addr), .brk_en(brk_en),
    .wch_addr(wch_addr), .wch_en(wch_en), .wch_rd(wch_rd), .wch_wr(wch_wr)
  );

  always_comb begin
    mode_n   = mode;
    cause_n  = cause;
    haddr_n  = haddr;
    drain_n  = drain_on;
    cnt_n    = cnt;
    halt_now = 1'b0;
    if (op_reset) begin
      mode_n  = M_RUN;
      cause_n = CAUSE_HOST;
      haddr_n = '0;
      drain_n = 1'b0;
    end else begin
      unique case (mode)
        M_RUN: begin
          halt_now = 1'b1;
          haddr_n  = inst_addr;
          if (brk_hit)                                      cause_n = CAUSE_BRK;
          else if (wch_hit)                                 cause_n = CAUSE_WCH;
          else if (drain_on && retire && cnt == CW'(1))     cause_n = CAUSE_EXT;
          else if (op_stop) begin
            cause_n = CAUSE_HOST;
            haddr_n = retire ? inst_addr : last_pc;
          end else begin
            halt_now = 1'b0;
            haddr_n  = haddr;
          end
          if (halt_now) begin
            mode_n  = M_HALT;
            drain_n = 1'b0;
          end else if (drain_on && retire) begin
            cnt_n = cnt - CW'(1);
          end else if (!drain_on && ext_s) begin
            drain_n = 1'b1;
            cnt_n   = CW'(DRAIN);
          end
        end
        M_HALT: begin
          if (op_resume)    mode_n = M_RUN;
          else if (op_step) mode_n = M_STEP;
        end
        default: begin
          if (op_resume) mode_n = M_RUN;
          else if (retire) begin
            mode_n  = M_HALT;
            haddr_n = inst_addr;
            cause_n = brk_hit ? CAUSE_BRK : (wch_hit ? CAUSE_WCH : CAUSE_STEP);
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode     <= M_RUN;
      cause    <= CAUSE_HOST;
      haddr    <= '0;
      last_pc  <= '0;
      drain_on <= 1'b0;
      cnt      <= '0;
      halted   <= 1'b0;
      core_run <= 1'b1;
      core_rst <= 1'b0;
    end else begin
      mode     <= mode_n;
      cause    <= cause_n;
      haddr    <= haddr_n;
      drain_on <= drain_n;
      cnt      <= cnt_n;
      halted   <= (mode_n != M_RUN);
      core_run <= (mode_n != M_HALT);
      core_rst <= op_reset;
      if (retire) last_pc <= inst_addr;
    end
  end
endmodule

// File: rtl/dbg_halt_ctrl_chk.sv
module dbg_halt_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       inst_valid,
  input logic       cmd_valid,
  input logic [2:0] cmd_op,
  input logic       halted,
  input logic       core_run,
  input logic       core_rst
);
  logic leave_cmd;
  assign leave_cmd = cmd_valid && (cmd_op == 3'd2 || cmd_op == 3'd4);

  AST_IDLE_RUNS: assert property (@(posedge clk) disable iff (rst)
    !halted |-> core_run); // R1

  AST_HALT_FREEZES: assert property (@(posedge clk) disable iff (rst)
    $rose(halted) |-> !core_run); // R2

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    (halted && !leave_cmd) |=> halted); // R6

  AST_RESUME_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (halted && cmd_valid && cmd_op == 3'd2) |=> (!halted && core_run)); // R6

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    (halted && core_run && inst_valid && !leave_cmd) |=> (halted && !core_run)); // R7

  AST_RST_PULSE: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 3'd4) |=> (core_rst && !halted)); // R8

  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (core_rst && !(cmd_valid && cmd_op == 3'd4)) |=> !core_rst); // R8
endmodule

bind dbg_halt_ctrl dbg_halt_ctrl_chk chk_i (
  .clk(clk), .rst(rst), .inst_valid(inst_valid), .cmd_valid(cmd_valid),
  .cmd_op(cmd_op), .halted(halted), .core_run(core_run), .core_rst(core_rst)
);

// File: tb/dbg_halt_ctrl_tb_top.sv
`timescale 1ns/1ps
module dbg_halt_ctrl_tb_top;
  localparam int DRAIN = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inst_valid = 0, dmem_valid = 0, dmem_wr = 0, ext_stop = 0;
  logic [15:0] inst_addr = 0, dmem_addr = 0, reg_wdata = 0;
  logic        cmd_valid = 0, reg_req = 0, reg_we = 0;
  logic [2:0]  cmd_op = 0;
  logic [4:0]  reg_addr = 0;
  logic [15:0] reg_rdata;
  logic        halted, core_run, core_rst;

  int checks = 0, fails = 0;
  string phase = "R1";

  always #2.5 clk = ~clk;

  dbg_halt_ctrl dut_i (
    .clk(clk), .rst(rst), .inst_valid(inst_valid), .inst_addr(inst_addr),
    .dmem_valid(dmem_valid), .dmem_wr(dmem_wr), .dmem_addr(dmem_addr),
    .ext_stop(ext_stop), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .halted(halted),
    .core_run(core_run), .core_rst(core_rst)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          m_mode, nxt, m_cause, m_cnt;   // mode: 0 run, 1 halted, 2 stepping
  bit          m_halted, m_run, m_crst, m_drain, s1, s2, m_live, ret, bph, wph;
  logic [15:0] m_haddr, m_last, m_rdata;
  logic [15:0] m_gpr[8];
  logic [15:0] bp_a[2], wp_a[2];
  bit          bp_e[2], wp_e[2], wp_r[2], wp_w[2];

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 0; m_halted = 0; m_run = 1; m_crst = 0; m_cause = 0;
      m_haddr = 0; m_last = 0; s1 = 0; s2 = 0; m_drain = 0; m_cnt = 0;
      m_rdata = 0; m_live = 1;
      for (int i = 0; i < 2; i++) begin
        bp_a[i] = 0; bp_e[i] = 0; wp_a[i] = 0; wp_e[i] = 0; wp_r[i] = 0; wp_w[i] = 0;
      end
    end else begin
      ret = m_run && inst_valid;
      bph = 0; wph = 0;
      for (int i = 0; i < 2; i++) begin
        if (ret && bp_e[i] && bp_a[i] == inst_addr) bph = 1;
        if (ret && dmem_valid && wp_e[i] && wp_a[i] == dmem_addr &&
            (dmem_wr ? wp_w[i] : wp_r[i])) wph = 1;
      end
      if (reg_req) begin
        m_rdata = 0;
        if (reg_addr < 8) m_rdata = m_gpr[reg_addr[2:0]];
        case (reg_addr)
          8: m_rdata = 16'(m_cause);
          9: m_rdata = m_haddr;
          10: m_rdata = 16'h0A51;
          11: m_rdata = {14'd0, m_mode == 2, m_mode != 0};
          16: m_rdata = bp_a[0];
          17: m_rdata = {15'd0, bp_e[0]};
          18: m_rdata = bp_a[1];
          19: m_rdata = {15'd0, bp_e[1]};
          24: m_rdata = wp_a[0];
          25: m_rdata = {13'd0, wp_w[0], wp_r[0], wp_e[0]};
          26: m_rdata = wp_a[1];
          27: m_rdata = {13'd0, wp_w[1], wp_r[1], wp_e[1]};
          default: ;
        endcase
      end
      m_crst = cmd_valid && cmd_op == 4;
      nxt = m_mode;
      if (m_crst) begin
        nxt = 0; m_cause = 0; m_haddr = 0; m_drain = 0;
      end else if (m_mode == 0) begin
        if (bph || wph || (m_drain && ret && m_cnt == 1) || (cmd_valid && cmd_op == 1)) begin
          nxt = 1; m_drain = 0;
          if (bph)      begin m_cause = 1; m_haddr = inst_addr; end
          else if (wph) begin m_cause = 2; m_haddr = inst_addr; end
          else if (ret && m_cnt == 1 && m_cause >= 0 && m_drain == 0 && !(cmd_valid && cmd_op == 1))
                        begin m_cause = 3; m_haddr = inst_addr; end
          else          begin m_cause = 0; m_haddr = ret ? inst_addr : m_last; end
        end else if (m_drain && ret) m_cnt--;
        else if (!m_drain && s2) begin m_drain = 1; m_cnt = DRAIN; end
      end else if (m_mode == 1) begin
        if (cmd_valid && cmd_op == 2) nxt = 0;
        else if (cmd_valid && cmd_op == 3) nxt = 2;
      end else begin
        if (cmd_valid && cmd_op == 2) nxt = 0;
        else if (ret) begin
          nxt = 1; m_haddr = inst_addr;
          m_cause = bph ? 1 : (wph ? 2 : 4);
        end
      end
      if (ret) m_last = inst_addr;
      s2 = s1; s1 = ext_stop;
      m_mode = nxt; m_halted = (nxt != 0); m_run = (nxt != 1);
      if (reg_req && reg_we) begin
        if (reg_addr < 8) m_gpr[reg_addr[2:0]] = reg_wdata;
        for (int i = 0; i < 2; i++) begin
          if (reg_addr == 16 + 2*i) bp_a[i] = reg_wdata;
          if (reg_addr == 17 + 2*i) bp_e[i] = reg_wdata[0];
          if (reg_addr == 24 + 2*i) wp_a[i] = reg_wdata;
          if (reg_addr == 25 + 2*i) begin
            wp_e[i] = reg_wdata[0]; wp_r[i] = reg_wdata[1]; wp_w[i] = reg_wdata[2];
          end
        end
      end
    end
  end

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (m_live && !rst) begin
      chk(halted == m_halted, phase, "halted", halted, m_halted);
      chk(core_run == m_run, phase, "core_run", core_run, m_run);
      chk(core_rst == m_crst, phase, "core_rst", core_rst, m_crst);
      chk(reg_rdata == m_rdata, phase, "reg_rdata", reg_rdata, m_rdata);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    reg_req = 1; reg_we = 1; reg_addr = 5'(a); reg_wdata = 16'(d);
    cyc(); reg_req = 0; reg_we = 0;
  endtask

  task automatic rd(input int a, input int exp, input string tag);
    reg_req = 1; reg_we = 0; reg_addr = 5'(a);
    cyc(); reg_req = 0;
    chk(reg_rdata == 16'(exp), tag, $sformatf("reg[%0d]", a), reg_rdata, exp);
  endtask

  task automatic cmd(input int op);
    cmd_valid = 1; cmd_op = 3'(op);
    cyc(); cmd_valid = 0; cmd_op = 0;
  endtask

  task automatic insts(input int start, input int n);
    for (int i = 0; i < n; i++) begin
      inst_valid = 1; inst_addr = 16'(start + i); cyc();
    end
    inst_valid = 0;
  endtask

  task automatic one(input int ia, input bit dw, input int da);
    inst_valid = 1; inst_addr = 16'(ia); dmem_valid = 1; dmem_wr = dw; dmem_addr = 16'(da);
    cyc(); inst_valid = 0; dmem_valid = 0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #500000;
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  // ---------------- test sequence ----------------
  initial begin
    cyc(3); rst = 0; cyc();
    phase = "R1";
    chk(halted == 0 && core_run == 1 && core_rst == 0, "R1", "reset outputs",
        {halted, core_run, core_rst}, 3'b010);
    rd(8, 0, "R1"); rd(11, 0, "R1"); rd(10, 16'h0A51, "R1");

    phase = "R9";
    wr(3, 16'h1234); wr(7, 16'hBEEF);
    rd(3, 16'h1234, "R9"); rd(7, 16'hBEEF, "R9");

    phase = "R10";
    wr(8, 7); wr(10, 0); wr(11, 3); wr(9, 16'h5555);
    rd(8, 0, "R10"); rd(10, 16'h0A51, "R10"); rd(11, 0, "R10"); rd(9, 0, "R10");

    phase = "R2";
    wr(16, 16'h0105); wr(17, 0);
    insts(16'h0100, 16);
    chk(halted == 0, "R2", "disabled bp no halt", halted, 0);
    wr(17, 1);
    insts(16'h0100, 16);
    chk(halted == 1 && core_run == 0, "R2", "bp halt", {halted, core_run}, 2'b10);
    rd(8, 1, "R2"); rd(9, 16'h0105, "R2"); rd(16, 16'h0105, "R2");

    phase = "R6";
    cyc(4);
    chk(halted == 1, "R6", "sticky", halted, 1);
    cmd(2);
    chk(halted == 0 && core_run == 1, "R6", "resume", {halted, core_run}, 2'b01);
    wr(17, 0);

    phase = "R4";
    cmd(1);
    chk(halted == 1 && core_run == 0, "R4", "host stop", {halted, core_run}, 2'b10);
    rd(8, 0, "R4"); rd(9, 16'h0105, "R4");

    phase = "R7";
    cmd(3);
    chk(halted == 1 && core_run == 1, "R7", "stepping", {halted, core_run}, 2'b11);
    rd(11, 3, "R7");
    insts(16'h0200, 3);
    chk(halted == 1 && core_run == 0, "R7", "after one step", {halted, core_run}, 2'b10);
    rd(8, 4, "R7"); rd(9, 16'h0200, "R7");

    phase = "R12";
    cmd(0); cmd(5); cmd(6); cmd(7);
    chk(halted == 1 && core_run == 0, "R12", "bad codes halted", {halted, core_run}, 2'b10);
    cmd(2); cmd(3); cmd(5);
    chk(halted == 0 && core_run == 1, "R12", "step while running", {halted, core_run}, 2'b01);

    phase = "R3";
    wr(24, 16'h0040); wr(25, 3);
    one(16'h0300, 1, 16'h0040);
    cyc();
    chk(halted == 0, "R3", "write to read-only wp", halted, 0);
    one(16'h0301, 0, 16'h0040);
    chk(halted == 1, "R3", "read hits wp", halted, 1);
    rd(8, 2, "R3"); rd(9, 16'h0301, "R3");
    cmd(2); wr(25, 5);
    one(16'h0302, 0, 16'h0040);
    cyc();
    chk(halted == 0, "R3", "read to write-only wp", halted, 0);
    one(16'h0303, 1, 16'h0040);
    rd(8, 2, "R3"); rd(9, 16'h0303, "R3");
    cmd(2); wr(25, 0);

    phase = "R11";
    wr(16, 16'h0310); wr(17, 1); wr(24, 16'h0050); wr(25, 3);
    cmd_valid = 1; cmd_op = 1;
    one(16'h0310, 0, 16'h0050);
    cmd_valid = 0; cmd_op = 0;
    rd(8, 1, "R11");
    cmd(2); wr(16, 16'h0311);
    cmd_valid = 1; cmd_op = 1;
    one(16'h0320, 0, 16'h0050);
    cmd_valid = 0; cmd_op = 0;
    rd(8, 2, "R11");
    cmd(2); wr(17, 0); wr(25, 0);

    phase = "R5";
    ext_stop = 1;
    insts(16'h0400, 10);
    rd(8, 3, "R5"); rd(9, 16'h0405, "R5");
    ext_stop = 0; cyc(3); cmd(2);
    insts(16'h0500, 8);
    chk(halted == 0, "R5", "no halt after release", halted, 0);

    phase = "R8";
    wr(18, 16'h0777); wr(19, 1);
    cmd(1);
    cmd(4);
    chk(core_rst == 1 && halted == 0, "R8", "reset pulse", {core_rst, halted}, 2'b10);
    cyc();
    chk(core_rst == 0, "R8", "pulse one cycle", core_rst, 0);
    rd(8, 0, "R8"); rd(9, 0, "R8"); rd(18, 16'h0777, "R8"); rd(19, 1, "R8");

    cyc(2);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule